// File: doc/BRIEF.md
# Rule Miss Trap Controller

This controller sits beside a tag-checking rule cache in a processor pipeline and manages the trip into and out of a privileged miss-handler mode. When the rule cache reports that no rule matches the current instruction, the controller latches the faulting program counter, the opcode and the full set of input tags. It exposes them as trap registers and switches the core into handler mode. In that mode the core also uses a separate bank of sixteen integer registers, so the handler never has to save user state.

While the handler runs, it writes the proposed output tags (new PC tag and result tag) into staging registers that accept writes only in handler mode. The handler finishes with a return strobe that carries an allow flag. On allow, the controller presents a one-cycle install strobe to the rule cache and, in the following cycle, a restart request at the faulting PC. On deny, it raises a one-cycle security fault instead.

A fixed isolation rule applies throughout. In handler mode, every fetched instruction and every touched data word must carry the reserved handler tag. In user mode, no access may touch a word that carries it. A second miss that arrives during handler mode is fatal and latches a double-fault state until reset.

States: `S_USER` (normal execution), `S_HANDLER` (miss handler running), `S_INSTALL` (install strobe), `S_RESTART` (restart request), `S_SECFLT` (security fault strobe), `S_DEAD` (double fault). Transitions:
- `S_USER` goes to `S_HANDLER` on a miss.
- `S_HANDLER` goes to `S_INSTALL` on a return with allow, to `S_SECFLT` on a return with deny, and to `S_DEAD` on a miss.
- `S_INSTALL` goes to `S_RESTART` unconditionally.
- `S_RESTART` goes to `S_USER` unconditionally.
- `S_SECFLT` goes to `S_USER` unconditionally.
- `S_DEAD` is left only by reset.

Top module: `tagmiss_trap_ctrl`

## Requirements
- R1: After reset the controller is in user mode, with handler_mode_o, hreg_bank_o, install_o, restart_o, sec_fault_o and double_fault_o all low, and both staged tags zero.
- R2: A miss_i pulse in user mode latches miss_pc_i, miss_op_i and miss_tags_i into trap_pc_o, trap_op_o and trap_tags_o, and handler_mode_o is high from the next cycle.
- R3: A write with hwr_en_i high stores hwr_data_i into the staged PC tag when hwr_sel_i is 0 and into the staged result tag when hwr_sel_i is 1, but only in handler mode; outside handler mode the write is ignored.
- R4: A handler return (hret_i) with hret_allow_i high in handler mode raises install_o for exactly one cycle. During that cycle the trap opcode, the trap tags and the staged tags are on the outputs. restart_o is high in the cycle after, with the restart address on trap_pc_o, and user mode follows.
- R5: A handler return with hret_allow_i low raises sec_fault_o for one cycle, with install_o and restart_o staying low, and then returns to user mode.
- R6: In handler mode, violation_o is high whenever a valid fetch or a valid data access carries a tag other than HANDLER_TAG.
- R7: In user mode, violation_o is high whenever a valid fetch or a valid data access carries HANDLER_TAG, and low for any other tag.
- R8: hreg_bank_o, which selects the sixteen handler-only integer registers, is high exactly while handler_mode_o is high.
- R9: A miss_i pulse in handler mode sets double_fault_o from the next cycle. It stays set until reset, handler mode ends, and later returns cause no install.
- R10: hret_i outside handler mode is ignored and causes no install, restart or security fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_i | input | 1 | Rule cache miss strobe |
| miss_pc_i | input | PC_W | PC of the faulting instruction |
| miss_op_i | input | OP_W | Opcode of the faulting instruction |
| miss_tags_i | input | N_TAGS*TAG_W | Input tags of the faulting instruction |
| hwr_en_i | input | 1 | Handler write to staged output tags |
| hwr_sel_i | input | 1 | 0: staged PC tag, 1: staged result tag |
| hwr_data_i | input | TAG_W | Tag value to stage |
| hret_i | input | 1 | Handler return strobe |
| hret_allow_i | input | 1 | 1: install rule, 0: security fault |
| fetch_vld_i | input | 1 | Instruction fetch valid |
| fetch_tag_i | input | TAG_W | Tag on fetched instruction |
| data_vld_i | input | 1 | Data access valid |
| data_tag_i | input | TAG_W | Tag on accessed data word |
| handler_mode_o | output | 1 | Core is in miss-handler mode |
| hreg_bank_o | output | 1 | Selects the handler-only register bank |
| trap_pc_o | output | PC_W | Trapped PC, also the restart address |
| trap_op_o | output | OP_W | Trapped opcode (install key) |
| trap_tags_o | output | N_TAGS*TAG_W | Trapped input tags (install key) |
| install_o | output | 1 | One-cycle rule install strobe |
| inst_pc_tag_o | output | TAG_W | Staged new PC tag |
| inst_res_tag_o | output | TAG_W | Staged result tag |
| restart_o | output | 1 | Restart request at trap_pc_o |
| sec_fault_o | output | 1 | One-cycle security fault strobe |
| double_fault_o | output | 1 | Sticky fatal double fault |
| violation_o | output | 1 | Tag isolation violation |

## Verification
The main sequence (miss, staged writes, return) runs from a table of four cases. The cases use distinct PCs, opcodes, tag sets and staged tags, so a crossed field or a wrong latch would show up. Allow and deny outcomes alternate across the table, which separates the install-then-restart path from the fault path and pins the exact cycle of each strobe. The isolation check is tried on both the fetch and the data port, in both modes, with the reserved tag and with other tags, to tell the user-mode rule apart from the handler-mode rule. Directed cases cover a write outside handler mode, a stray return, and a second miss inside the handler.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
    typedef enum logic [2:0] {
        S_USER    = 3'd0,
        S_HANDLER = 3'd1,
        S_INSTALL = 3'd2,
        S_RESTART = 3'd3,
        S_SECFLT  = 3'd4,
        S_DEAD    = 3'd5
    } tmt_state_e;
endpackage

// File: rtl/tmt_fsm.sv
module tmt_fsm
    import tmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss,
    input  logic hret,
    input  logic hret_allow,
    output logic capture_en,
    output logic in_handler,
    output logic install,
    output logic restart,
    output logic sec_fault,
    output logic dead
);
    tmt_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_USER;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_USER:    if (miss) nxt = S_HANDLER;
            S_HANDLER: begin
                if (miss)      nxt = S_DEAD;
                else if (hret) nxt = hret_allow ? S_INSTALL : S_SECFLT;
            end
            S_INSTALL: nxt = S_RESTART;
            S_RESTART: nxt = S_USER;
            S_SECFLT:  nxt = S_USER;
            S_DEAD:    nxt = S_DEAD;
            default:   nxt = S_USER;
        endcase
    end

    always_comb begin
        capture_en = (state == S_USER) && miss;
        in_handler = (state == S_HANDLER);
        install    = (state == S_INSTALL);
        restart    = (state == S_RESTART);
        sec_fault  = (state == S_SECFLT);
        dead       = (state == S_DEAD);
    end
endmodule

// File: rtl/tmt_capture.sv
module tmt_capture #(
    parameter int PC_W = 32,
    parameter int OP_W = 8,
    parameter int KW   = 80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [PC_W-1:0] pc_in,
    input  logic [OP_W-1:0] op_in,
    input  logic [KW-1:0]   tags_in,
    output logic [PC_W-1:0] pc_q,
    output logic [OP_W-1:0] op_q,
    output logic [KW-1:0]   tags_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            op_q   <= '0;
            tags_q <= '0;
        end else if (en) begin
            pc_q   <= pc_in;
            op_q   <= op_in;
            tags_q <= tags_in;
        end
    end
endmodule

// File: rtl/tmt_stage.sv
module tmt_stage #(
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [TAG_W-1:0] data,
    output logic [TAG_W-1:0] pc_tag,
    output logic [TAG_W-1:0] res_tag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_tag  <= '0;
            res_tag <= '0;
        end else if (wr) begin
            if (sel) res_tag <= data;
            else     pc_tag  <= data;
        end
    end
endmodule

// File: rtl/tmt_guard.sv
module tmt_guard #(
    parameter int             TAG_W       = 16,
    parameter logic [TAG_W-1:0] HANDLER_TAG = '1
) (
    input  logic             handler,
    input  logic             f_vld,
    input  logic [TAG_W-1:0] f_tag,
    input  logic             d_vld,
    input  logic [TAG_W-1:0] d_tag,
    output logic             viol
);
    logic f_is_h, d_is_h;
    always_comb begin
        f_is_h = (f_tag == HANDLER_TAG);
        d_is_h = (d_tag == HANDLER_TAG);
        if (handler) viol = (f_vld && !f_is_h) || (d_vld && !d_is_h);
        else         viol = (f_vld && f_is_h)  || (d_vld && d_is_h);
    end
endmodule

// File: rtl/tagmiss_trap_ctrl.sv
module tagmiss_trap_ctrl #(
    parameter int               PC_W        = 32,
    parameter int               OP_W        = 8,
    parameter int               TAG_W       = 16,
    parameter int               N_TAGS      = 5,
    parameter logic [TAG_W-1:0] HANDLER_TAG = '1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_i,
    input  logic [PC_W-1:0]         miss_pc_i,
    input  logic [OP_W-1:0]         miss_op_i,
    input  logic [N_TAGS*TAG_W-1:0] miss_tags_i,
    input  logic                    hwr_en_i,
    input  logic                    hwr_sel_i,
    input  logic [TAG_W-1:0]        hwr_data_i,
    input  logic                    hret_i,
    input  logic                    hret_allow_i,
    input  logic                    fetch_vld_i,
    input  logic [TAG_W-1:0]        fetch_tag_i,
    input  logic                    data_vld_i,
    input  logic [TAG_W-1:0]        data_tag_i,
    output logic                    handler_mode_o,
    output logic                    hreg_bank_o,
    output logic [PC_W-1:0]         trap_pc_o,
    output logic [OP_W-1:0]         trap_op_o,
    output logic [N_TAGS*TAG_W-1:0] trap_tags_o,
    output logic                    install_o,
    output logic [TAG_W-1:0]        inst_pc_tag_o,
    output logic [TAG_W-1:0]        inst_res_tag_o,
    output logic                    restart_o,
    output logic                    sec_fault_o,
    output logic                    double_fault_o,
    output logic                    violation_o
);
    localparam int KEY_W = N_TAGS * TAG_W;

    logic cap_en, in_h;

    tmt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss       (miss_i),
        .hret       (hret_i),
        .hret_allow (hret_allow_i),
        .capture_en (cap_en),
        .in_handler (in_h),
        .install    (install_o),
        .restart    (restart_o),
        .sec_fault  (sec_fault_o),
        .dead       (double_fault_o)
    );

    tmt_capture #(.PC_W(PC_W), .OP_W(OP_W), .KW(KEY_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cap_en),
        .pc_in   (miss_pc_i),
        .op_in   (miss_op_i),
        .tags_in (miss_tags_i),
        .pc_q    (trap_pc_o),
        .op_q    (trap_op_o),
        .tags_q  (trap_tags_o)
    );

    tmt_stage #(.TAG_W(TAG_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (hwr_en_i && in_h),
        .sel     (hwr_sel_i),
        .data    (hwr_data_i),
        .pc_tag  (inst_pc_tag_o),
        .res_tag (inst_res_tag_o)
    );

    tmt_guard #(.TAG_W(TAG_W), .HANDLER_TAG(HANDLER_TAG)) u_guard (
        .handler (in_h),
        .f_vld   (fetch_vld_i),
        .f_tag   (fetch_tag_i),
        .d_vld   (data_vld_i),
        .d_tag   (data_tag_i),
        .viol    (violation_o)
    );

    assign handler_mode_o = in_h;
    assign hreg_bank_o    = in_h;
endmodule

// File: rtl/tagmiss_trap_ctrl_chk.sv
module tagmiss_trap_ctrl_chk #(
    parameter int               PC_W        = 32,
    parameter int               TAG_W       = 16,
    parameter logic [TAG_W-1:0] HANDLER_TAG = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_i,
    input logic [PC_W-1:0]  miss_pc_i,
    input logic             hret_i,
    input logic             hret_allow_i,
    input logic             fetch_vld_i,
    input logic [TAG_W-1:0] fetch_tag_i,
    input logic             handler_mode_o,
    input logic [PC_W-1:0]  trap_pc_o,
    input logic             install_o,
    input logic             restart_o,
    input logic             sec_fault_o,
    input logic             double_fault_o,
    input logic             violation_o
);
    // R2
    trap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(handler_mode_o) |-> ($past(miss_i) && trap_pc_o == $past(miss_pc_i)));

    // R4
    install_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        install_o |=> (!install_o && restart_o));

    // R4
    install_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_mode_o && hret_i && hret_allow_i && !miss_i) |=> install_o);

    // R5
    deny_no_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_fault_o |-> (!install_o && !restart_o && !handler_mode_o));

    // R6
    handler_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_mode_o && fetch_vld_i && fetch_tag_i != HANDLER_TAG) |-> violation_o);

    // R9
    double_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        double_fault_o |=> (double_fault_o && !handler_mode_o && !install_o));

    // R9
    double_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_mode_o && miss_i) |=> double_fault_o);
endmodule

bind tagmiss_trap_ctrl tagmiss_trap_ctrl_chk #(
    .PC_W(PC_W), .TAG_W(TAG_W), .HANDLER_TAG(HANDLER_TAG)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_i         (miss_i),
    .miss_pc_i      (miss_pc_i),
    .hret_i         (hret_i),
    .hret_allow_i   (hret_allow_i),
    .fetch_vld_i    (fetch_vld_i),
    .fetch_tag_i    (fetch_tag_i),
    .handler_mode_o (handler_mode_o),
    .trap_pc_o      (trap_pc_o),
    .install_o      (install_o),
    .restart_o      (restart_o),
    .sec_fault_o    (sec_fault_o),
    .double_fault_o (double_fault_o),
    .violation_o    (violation_o)
);

// File: tb/test_tagmiss_trap_ctrl.sv
module test_tagmiss_trap_ctrl;
    localparam int PC_W = 32;
    localparam int OP_W = 8;
    localparam int TAG_W = 16;
    localparam int N_TAGS = 5;
    localparam int KW = N_TAGS * TAG_W;
    localparam logic [TAG_W-1:0] HT = 16'hFFFF;
    localparam int NV = 4;

    localparam logic [PC_W-1:0] V_PC [NV] = '{32'h0000_1000, 32'h8000_0044, 32'h0BAD_F00C, 32'hFFFF_FFFC};
    localparam logic [OP_W-1:0] V_OP [NV] = '{8'h11, 8'hA5, 8'h3C, 8'hFE};
    localparam logic [KW-1:0]   V_TG [NV] = '{80'h0001_0002_0003_0004_0005, 80'hAAAA_5555_0000_FFFF_1234,
                                              80'h0000_0000_0000_0000_0001, 80'hDEAD_BEEF_CAFE_0F0F_7777};
    localparam logic [TAG_W-1:0] V_PT [NV] = '{16'h0007, 16'h1234, 16'h8001, 16'h00FF};
    localparam logic [TAG_W-1:0] V_RT [NV] = '{16'h0009, 16'h4321, 16'h7FFE, 16'hFF00};
    localparam logic            V_AL [NV] = '{1'b1, 1'b0, 1'b1, 1'b0};

    logic clk = 0, rst_n = 0;
    logic miss_i = 0, hwr_en_i = 0, hwr_sel_i = 0, hret_i = 0, hret_allow_i = 0;
    logic fetch_vld_i = 0, data_vld_i = 0;
    logic [PC_W-1:0] miss_pc_i = '0;
    logic [OP_W-1:0] miss_op_i = '0;
    logic [KW-1:0] miss_tags_i = '0;
    logic [TAG_W-1:0] hwr_data_i = '0, fetch_tag_i = '0, data_tag_i = '0;
    logic handler_mode_o, hreg_bank_o, install_o, restart_o, sec_fault_o, double_fault_o, violation_o;
    logic [PC_W-1:0] trap_pc_o;
    logic [OP_W-1:0] trap_op_o;
    logic [KW-1:0] trap_tags_o;
    logic [TAG_W-1:0] inst_pc_tag_o, inst_res_tag_o;

    int n_run = 0, n_fail = 0, cyc = 0;
    logic [TAG_W-1:0] keep_pt;

    always #5 clk = ~clk;

    tagmiss_trap_ctrl #(.PC_W(PC_W), .OP_W(OP_W), .TAG_W(TAG_W), .N_TAGS(N_TAGS), .HANDLER_TAG(HT)) i_tagmiss_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .miss_pc_i(miss_pc_i), .miss_op_i(miss_op_i),
        .miss_tags_i(miss_tags_i), .hwr_en_i(hwr_en_i), .hwr_sel_i(hwr_sel_i), .hwr_data_i(hwr_data_i),
        .hret_i(hret_i), .hret_allow_i(hret_allow_i), .fetch_vld_i(fetch_vld_i), .fetch_tag_i(fetch_tag_i),
        .data_vld_i(data_vld_i), .data_tag_i(data_tag_i), .handler_mode_o(handler_mode_o),
        .hreg_bank_o(hreg_bank_o), .trap_pc_o(trap_pc_o), .trap_op_o(trap_op_o), .trap_tags_o(trap_tags_o),
        .install_o(install_o), .inst_pc_tag_o(inst_pc_tag_o), .inst_res_tag_o(inst_res_tag_o),
        .restart_o(restart_o), .sec_fault_o(sec_fault_o), .double_fault_o(double_fault_o),
        .violation_o(violation_o)
    );

    task automatic chk(input string req, input logic [KW-1:0] act, input logic [KW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 mode", handler_mode_o, 0);
        chk("R1 bank", hreg_bank_o, 0);
        chk("R1 strobes", {install_o, restart_o, sec_fault_o, double_fault_o}, 0);
        chk("R1 staged", {inst_pc_tag_o, inst_res_tag_o}, 0);

        for (int i = 0; i < NV; i++) begin
            miss_i = 1; miss_pc_i = V_PC[i]; miss_op_i = V_OP[i]; miss_tags_i = V_TG[i];
            step();
            miss_i = 0; miss_pc_i = '0; miss_op_i = '0; miss_tags_i = '0;
            chk("R2 mode", handler_mode_o, 1);
            chk("R2 pc", trap_pc_o, V_PC[i]);
            chk("R2 op", trap_op_o, V_OP[i]);
            chk("R2 tags", trap_tags_o, V_TG[i]);
            chk("R8 bank", hreg_bank_o, 1);
            hwr_en_i = 1; hwr_sel_i = 0; hwr_data_i = V_PT[i];
            step();
            hwr_sel_i = 1; hwr_data_i = V_RT[i];
            step();
            hwr_en_i = 0;
            chk("R3 pc tag", inst_pc_tag_o, V_PT[i]);
            chk("R3 res tag", inst_res_tag_o, V_RT[i]);
            hret_i = 1; hret_allow_i = V_AL[i];
            step();
            hret_i = 0; hret_allow_i = 0;
            if (V_AL[i]) begin
                chk("R4 install", install_o, 1);
                chk("R4 no early restart", restart_o, 0);
                chk("R4 key op", trap_op_o, V_OP[i]);
                chk("R4 key tags", trap_tags_o, V_TG[i]);
                chk("R4 out tags", {inst_pc_tag_o, inst_res_tag_o}, {V_PT[i], V_RT[i]});
                step();
                chk("R4 install single", install_o, 0);
                chk("R4 restart", restart_o, 1);
                chk("R4 restart pc", trap_pc_o, V_PC[i]);
                step();
                chk("R4 back to user", {handler_mode_o, restart_o}, 0);
            end else begin
                chk("R5 fault", sec_fault_o, 1);
                chk("R5 no install", {install_o, restart_o}, 0);
                step();
                chk("R5 fault single", sec_fault_o, 0);
                chk("R5 user", {handler_mode_o, install_o, restart_o}, 0);
            end
            chk("R8 bank off", hreg_bank_o, 0);
        end

        // R3 write outside handler mode is ignored
        keep_pt = inst_pc_tag_o;
        hwr_en_i = 1; hwr_sel_i = 0; hwr_data_i = 16'h5A5A;
        step();
        hwr_en_i = 0;
        chk("R3 user write ignored", inst_pc_tag_o, keep_pt);

        // R10 stray return in user mode
        hret_i = 1; hret_allow_i = 1;
        step();
        hret_i = 0; hret_allow_i = 0;
        chk("R10 no install", {install_o, sec_fault_o, handler_mode_o}, 0);
        step();
        chk("R10 no restart", restart_o, 0);

        // R7 user-mode tag checks
        fetch_vld_i = 1; fetch_tag_i = HT; #1;
        chk("R7 fetch handler tag", violation_o, 1);
        fetch_tag_i = 16'h0001; #1;
        chk("R7 fetch other tag", violation_o, 0);
        fetch_vld_i = 0; data_vld_i = 1; data_tag_i = HT; #1;
        chk("R7 data handler tag", violation_o, 1);
        data_tag_i = 16'h0100; #1;
        chk("R7 data other tag", violation_o, 0);
        data_vld_i = 0;

        // enter handler mode for R6 and R9
        miss_i = 1; miss_pc_i = 32'h0000_2000;
        step();
        miss_i = 0;
        fetch_vld_i = 1; fetch_tag_i = 16'h0001; #1;
        chk("R6 fetch non-handler tag", violation_o, 1);
        fetch_tag_i = HT; #1;
        chk("R6 fetch handler tag", violation_o, 0);
        fetch_vld_i = 0; data_vld_i = 1; data_tag_i = 16'h0000; #1;
        chk("R6 data non-handler tag", violation_o, 1);
        data_tag_i = HT; #1;
        chk("R6 data handler tag", violation_o, 0);
        data_vld_i = 0;

        // R9 second miss inside handler mode
        miss_i = 1; miss_pc_i = 32'h0000_3000;
        step();
        miss_i = 0;
        chk("R9 double fault", double_fault_o, 1);
        chk("R9 mode ends", handler_mode_o, 0);
        hret_i = 1; hret_allow_i = 1;
        step();
        hret_i = 0; hret_allow_i = 0;
        chk("R9 no install", install_o, 0);
        step(); step();
        chk("R9 sticky", double_fault_o, 1);
        chk("R9 trap pc kept", trap_pc_o, 32'h0000_2000);

        rst_n = 0;
        step();
        rst_n = 1;
        step();
        chk("R1 reset clears double fault", double_fault_o, 0);
        chk("R1 reset mode", handler_mode_o, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule